// File: doc/BRIEF.md
# FIFO-Chunked Transfer Sequencer

This block moves a programmed number of bytes between a 512-byte staging FIFO and a card-side word port. The host side sees the transfer in chunks. Before each chunk the block raises a buffer-available pulse. On a read, the pulse means the FIFO holds the whole chunk. On a write, it means the FIFO has room for the whole chunk. After the pulse the host may pop or push exactly that many bytes, one per cycle. Every chunk is 512 bytes except the last, which carries whatever remains.

One 32-bit control word sets up a transfer. It carries the byte count, the direction, the card word width, an address-hold flag, a DMA-routing flag and the start flag. Setting start on an idle sequencer with a legal count launches the transfer. The start flag stays high while the transfer is in flight. It drops when the transfer completes, when software writes the word with start low, or when the card side reports an error. Completion is marked by a one-cycle done pulse. An abort empties the FIFO and gives no done pulse.

The card side is a plain request/acknowledge word handshake with an address output. A word is one byte in 8-bit mode and two bytes in 16-bit mode, with the low byte first. If a 16-bit transfer has an odd count, its final word carries one byte.

Top module: `xfer_chunk_seq`

## Requirements
- R1: The control word reads back on `ctl_q` with the byte count in bits [17:0], address hold in bit 24, 16-bit width in bit 25, DMA routing in bit 28, direction in bit 30 (1 = host writes toward the card, 0 = card data read toward the host) and start in bit 31. All other bits read 0, and the whole word is 0 after reset.
- R2: Setting start takes effect only if the sequencer is idle and the count is between 1 and 0x20000. With a count of zero or above 0x20000, the other fields are stored and start stays 0. A control write that has start high while a transfer runs changes nothing.
- R3: On a read, the card delivers data through `card_req`/`card_ack`, and the host pops the bytes in card order. `card_addr` starts at 0 and advances by the bytes of each word, unless address hold is set, in which case it stays at 0.
- R4: On a read, one buffer-available pulse fires per chunk, once the FIFO holds min(512, bytes not yet popped). In 8-bit mode, the first pulse appears (chunk + 1) clock edges after the edge that accepts start.
- R5: On a write, a pulse fires once the FIFO has min(512, bytes not yet pushed) bytes of free space. The first pulse appears on the second edge after start. The card receives the pushed bytes in order.
- R6: Host pushes and pops are ignored unless they fall inside a chunk granted by a pulse. They do not affect data or count.
- R7: In 16-bit mode each handshake moves two bytes (`card_wide` = 1). An odd count ends with one single-byte handshake (`card_wide` = 0).
- R8: With the DMA bit set, each pulse appears on `dma_req` and never on `buf_irq`. With the DMA bit clear, the reverse holds.
- R9: `xfer_done` pulses for one cycle on the edge after the last byte has left the FIFO, and start reads 0 from that same cycle.
- R10: Writing the control word with start low during a transfer, or asserting `xfer_err`, stops the transfer on that edge. Start reads 0, `card_req` falls, the FIFO is emptied, and no done pulse or buffer pulse follows.
- R11: The FIFO never holds more than 512 bytes. On a read, the card is stalled (`card_req` low) while the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_q | output | 32 | Current control word |
| xfer_err | input | 1 | Card-side transfer error, aborts the transfer |
| buf_irq | output | 1 | Buffer-available pulse, interrupt routing |
| dma_req | output | 1 | Buffer-available pulse, DMA routing |
| xfer_done | output | 1 | Transfer complete pulse |
| hst_push | input | 1 | Host pushes one byte (write direction) |
| hst_wdata | input | 8 | Host push byte |
| hst_pop | input | 1 | Host pops one byte (read direction) |
| hst_rdata | output | 8 | FIFO head byte |
| card_req | output | 1 | Card word request |
| card_ack | input | 1 | Card word acknowledge |
| card_addr | output | 11 | Card byte address |
| card_wide | output | 1 | Current word carries two bytes |
| card_wdata | output | 16 | Word toward the card, low byte first |
| card_rdata | input | 16 | Word from the card, low byte first |

## Verification
Every result below is given as a cycle offset, and the bench samples it at that offset. A start, abort or error acts on the edge that samples the strobe. The read on the following falling edge must already show the new start bit and a low `card_req`.

With an always-ready card, the first read pulse is due on the falling edge (words + 2) after the one that drove the start write. The first write pulse is due on the second such edge. The bench counts falling edges from the start write to catch both exactly.

The done pulse is due one edge after the final host pop. The bench checks that done is still low on the falling edge just after that pop and high on the next one.

// File: rtl/xfer_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared layout of the control word for the chunked transfer sequencer.
// Assumes a 32-bit control word; field positions are fixed by the software view.
package xfer_seq_pkg;
    localparam int CNT_W = 18;

    typedef struct packed {
        logic             start;   // bit 31
        logic             wr;      // bit 30: 1 host->card, 0 card->host
        logic             rsv29;
        logic             dma;     // bit 28: route pulses to dma_req
        logic [1:0]       rsv27;
        logic             w16;     // bit 25: two bytes per card word
        logic             hold;    // bit 24: freeze card address
        logic [5:0]       rsv23;
        logic [CNT_W-1:0] count;   // bits 17:0: byte count
    } ctl_t;

    typedef enum logic {PH_WAIT, PH_HOST} phase_e;
endpackage

// File: rtl/xfer_byte_fifo.sv
`timescale 1ns/1ps
// Module: byte FIFO with up to two bytes in and two bytes out per cycle.
// Assumes DEPTH is a power of two and that callers never push past free
// space or pop past level; flush empties it in one cycle.
module xfer_byte_fifo #(
    parameter int DEPTH = 512,
    localparam int PW = $clog2(DEPTH),
    localparam int LW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    in_n,
    input  logic [15:0]   in_data,
    input  logic [1:0]    out_n,
    output logic [15:0]   out_data,
    output logic [LW-1:0] level,
    output logic [LW-1:0] free
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [PW-1:0] wptr_nx, rptr_nx;

    assign wptr_nx  = wptr + 1'b1;
    assign rptr_nx  = rptr + 1'b1;
    assign out_data = {mem[rptr_nx], mem[rptr]};
    assign free     = LW'(DEPTH) - level;

    // Storage writes, low byte first.
    always_ff @(posedge clk) begin
        if (in_n != 2'd0) mem[wptr] <= in_data[7:0];
        if (in_n == 2'd2) mem[wptr_nx] <= in_data[15:8];
    end

    // Pointer and occupancy tracking, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            wptr  <= wptr + PW'(in_n);
            rptr  <= rptr + PW'(out_n);
            level <= level + LW'(in_n) - LW'(out_n);
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (LW'(in_n) <= free + LW'(out_n))); // R11
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (LW'(out_n) <= level)); // R11
endmodule

// File: rtl/xfer_card_port.sv
`timescale 1ns/1ps
// Module: card-side word handshake. Requests a word when the FIFO can take
// or supply it, tracks bytes left for the card and the card byte address.
// Assumes load only arrives while run is low.
module xfer_card_port #(
    parameter int CNT_W  = 18,
    parameter int ADDR_W = 11,
    parameter int LW     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [CNT_W-1:0]  count,
    input  logic              run,
    input  logic              wr_dir,
    input  logic              w16,
    input  logic              hold,
    input  logic [LW-1:0]     level,
    input  logic [LW-1:0]     free,
    input  logic              ack,
    output logic              req,
    output logic              wide,
    output logic [ADDR_W-1:0] addr,
    output logic              fire,
    output logic [1:0]        nbytes,
    output logic              left_zero
);
    logic [CNT_W-1:0] left;

    // Word size: two bytes in wide mode unless only one byte remains.
    assign wide      = w16 && (left > CNT_W'(1));
    assign nbytes    = wide ? 2'd2 : 2'd1;
    assign left_zero = (left == '0);
    assign req       = run && !left_zero &&
                       (wr_dir ? (level >= LW'(nbytes)) : (free >= LW'(nbytes)));
    assign fire      = req && ack;

    // Remaining card bytes and card address.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            left <= '0;
            addr <= '0;
        end else if (load) begin
            left <= count;
            addr <= '0;
        end else if (fire) begin
            left <= left - CNT_W'(nbytes);
            if (!hold) addr <= addr + ADDR_W'(nbytes);
        end
    end

    AST_CARD_LEFT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clear) |=> (left < $past(left))); // R3
endmodule

// File: rtl/xfer_pacer.sv
`timescale 1ns/1ps
// Module: host-side chunk pacing. Grants the host one chunk of at most
// FIFO_BYTES at a time, raising a one-cycle pulse when the FIFO holds the
// chunk (read) or has room for it (write). Counts host bytes left.
module xfer_pacer
    import xfer_seq_pkg::*;
#(
    parameter int CNT_W      = 18,
    parameter int FIFO_BYTES = 512,
    parameter int LW         = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] count,
    input  logic             run,
    input  logic             wr_dir,
    input  logic [LW-1:0]    level,
    input  logic [LW-1:0]    free,
    input  logic             host_op,
    output logic             host_ok,
    output logic             evt,
    output logic             left_zero
);
    phase_e           phase;
    logic [CNT_W-1:0] host_left;
    logic [CNT_W-1:0] chunk_sz;
    logic [LW-1:0]    chunk_rem;
    logic [LW-1:0]    avail;

    assign chunk_sz  = (host_left > CNT_W'(FIFO_BYTES)) ? CNT_W'(FIFO_BYTES) : host_left;
    assign avail     = wr_dir ? free : level;
    assign host_ok   = (phase == PH_HOST);
    assign left_zero = (host_left == '0);

    // Chunk grant, host byte accounting and event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase     <= PH_WAIT;
            host_left <= '0;
            chunk_rem <= '0;
            evt       <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (load) begin
                host_left <= count;
                phase     <= PH_WAIT;
            end else if (run) begin
                case (phase)
                    PH_WAIT: if (!left_zero && (CNT_W'(avail) >= chunk_sz)) begin
                        phase     <= PH_HOST;
                        chunk_rem <= LW'(chunk_sz);
                        evt       <= 1'b1;
                    end
                    PH_HOST: if (host_op) begin
                        host_left <= host_left - 1'b1;
                        chunk_rem <= chunk_rem - 1'b1;
                        if (chunk_rem == LW'(1)) phase <= PH_WAIT;
                    end
                    default: phase <= PH_WAIT;
                endcase
            end
        end
    end

    AST_CHUNK_WITHIN_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        host_ok |-> (chunk_rem != '0 && chunk_rem <= LW'(FIFO_BYTES))); // R4
    AST_EVT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt); // R4
endmodule

// File: rtl/xfer_chunk_seq.sv
`timescale 1ns/1ps
// Module: top of the FIFO-chunked transfer sequencer. Holds the control
// word, decides start/abort/done, and steers the FIFO ports between host
// and card by direction. Assumes an always-clocked card handshake.
module xfer_chunk_seq
    import xfer_seq_pkg::*;
#(
    parameter int          FIFO_BYTES = 512,
    parameter int          ADDR_W     = 11,
    parameter int unsigned MAX_BYTES  = 32'h20000,
    localparam int         LW         = $clog2(FIFO_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_q,
    input  logic              xfer_err,
    output logic              buf_irq,
    output logic              dma_req,
    output logic              xfer_done,
    input  logic              hst_push,
    input  logic [7:0]        hst_wdata,
    input  logic              hst_pop,
    output logic [7:0]        hst_rdata,
    output logic              card_req,
    input  logic              card_ack,
    output logic [ADDR_W-1:0] card_addr,
    output logic              card_wide,
    output logic [15:0]       card_wdata,
    input  logic [15:0]       card_rdata
);
    ctl_t             ctl;
    logic             active, start_go, abort, done_now, flush;
    logic [CNT_W-1:0] wr_count;
    logic             host_ok, host_eff, evt, host_zero, card_zero;
    logic             card_fire;
    logic [1:0]       card_n, fifo_in_n, fifo_out_n;
    logic [15:0]      fifo_in_data, fifo_out_data;
    logic [LW-1:0]    fifo_level, fifo_free;
    wire              unused_rsv_bits = ^{ctl_wdata[29], ctl_wdata[27:26], ctl_wdata[23:18]};

    assign active   = ctl.start;
    assign wr_count = ctl_wdata[CNT_W-1:0];
    assign start_go = ctl_wr && !active && ctl_wdata[31] &&
                      (wr_count != '0) && (32'(wr_count) <= MAX_BYTES);
    assign abort    = active && ((ctl_wr && !ctl_wdata[31]) || xfer_err);
    assign done_now = active && host_zero && card_zero && !abort;
    assign flush    = abort || start_go;
    assign ctl_q    = ctl;

    // Control word register with start/abort/done handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl       <= '0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= done_now;
            if (abort || done_now) begin
                ctl.start <= 1'b0;
            end else if (ctl_wr && !active) begin
                ctl.start <= start_go;
                ctl.wr    <= ctl_wdata[30];
                ctl.dma   <= ctl_wdata[28];
                ctl.w16   <= ctl_wdata[25];
                ctl.hold  <= ctl_wdata[24];
                ctl.count <= wr_count;
            end
        end
    end

    // Steer FIFO ports between host and card by direction.
    assign host_eff     = host_ok && (ctl.wr ? hst_push : hst_pop);
    assign fifo_in_n    = ctl.wr ? {1'b0, host_eff} : (card_fire ? card_n : 2'd0);
    assign fifo_in_data = ctl.wr ? {8'h00, hst_wdata} : card_rdata;
    assign fifo_out_n   = ctl.wr ? (card_fire ? card_n : 2'd0) : {1'b0, host_eff};
    assign hst_rdata    = fifo_out_data[7:0];
    assign card_wdata   = fifo_out_data;
    assign buf_irq      = evt && !ctl.dma;
    assign dma_req      = evt && ctl.dma;

    xfer_byte_fifo #(.DEPTH(FIFO_BYTES)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_n(fifo_in_n), .in_data(fifo_in_data),
        .out_n(fifo_out_n), .out_data(fifo_out_data),
        .level(fifo_level), .free(fifo_free)
    );

    xfer_card_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LW(LW)) u_card (
        .clk(clk), .rst_n(rst_n), .load(start_go), .clear(abort),
        .count(wr_count), .run(active), .wr_dir(ctl.wr), .w16(ctl.w16),
        .hold(ctl.hold), .level(fifo_level), .free(fifo_free), .ack(card_ack),
        .req(card_req), .wide(card_wide), .addr(card_addr), .fire(card_fire),
        .nbytes(card_n), .left_zero(card_zero)
    );

    xfer_pacer #(.CNT_W(CNT_W), .FIFO_BYTES(FIFO_BYTES), .LW(LW)) u_pacer (
        .clk(clk), .rst_n(rst_n), .load(start_go), .clear(abort),
        .count(wr_count), .run(active), .wr_dir(ctl.wr),
        .level(fifo_level), .free(fifo_free), .host_op(host_eff),
        .host_ok(host_ok), .evt(evt), .left_zero(host_zero)
    );

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ctl_wr && ctl_wdata[31] && !xfer_err && !done_now) |=> (ctl_q == $past(ctl_q))); // R2
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!ctl_q[31] && !card_req && fifo_level == '0 && !xfer_done)); // R10
    AST_DONE_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !ctl_q[31]); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R9
    AST_EVT_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_irq || dma_req) |-> ctl_q[31]); // R4
endmodule

// File: tb/xfer_chunk_seq_test.sv
`timescale 1ns/1ps
module xfer_chunk_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_wr;
    logic [31:0] ctl_wdata;
    logic [31:0] ctl_q;
    logic        xfer_err;
    logic        buf_irq, dma_req, xfer_done;
    logic        hst_push, hst_pop;
    logic [7:0]  hst_wdata, hst_rdata;
    logic        card_req, card_ack, card_wide;
    logic [10:0] card_addr;
    logic [15:0] card_wdata, card_rdata;

    int n_vec = 0, n_bad = 0;
    int n_irq, n_dma, n_done, n_wide, n_narrow;
    bit finished = 0;
    logic [7:0] cmem [2048];

    always #2.5 clk = ~clk;

    xfer_chunk_seq uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .xfer_err(xfer_err), .buf_irq(buf_irq), .dma_req(dma_req),
        .xfer_done(xfer_done), .hst_push(hst_push), .hst_wdata(hst_wdata),
        .hst_pop(hst_pop), .hst_rdata(hst_rdata), .card_req(card_req),
        .card_ack(card_ack), .card_addr(card_addr), .card_wide(card_wide),
        .card_wdata(card_wdata), .card_rdata(card_rdata)
    );

    function automatic logic [7:0] fpat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] gpat(input int k);
        return 8'((k * 13 + 5) & 255);
    endfunction

    assign card_rdata = {fpat(int'(card_addr) + 1), fpat(int'(card_addr))};

    // Card model and event monitors.
    always @(posedge clk) begin
        if (buf_irq) n_irq++;
        if (dma_req) n_dma++;
        if (xfer_done) n_done++;
        if (card_req && card_ack) begin
            if (card_wide) n_wide++; else n_narrow++;
            cmem[card_addr] <= card_wdata[7:0];
            if (card_wide) cmem[11'(card_addr + 11'd1)] <= card_wdata[15:8];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_irq = 0; n_dma = 0; n_done = 0; n_wide = 0; n_narrow = 0;
    endtask

    function automatic logic [31:0] ctlw(input bit st, input bit wr, input bit dma,
                                         input bit w16, input bit hold, input int cnt);
        return {st, wr, 1'b0, dma, 2'b00, w16, hold, 6'd0, 18'(cnt)};
    endfunction

    task automatic wait_evt(inout int waitn);
        int w = 0;
        while (!(buf_irq || dma_req) && w < 6000) begin
            @(negedge clk); waitn++; w++;
        end
    endtask

    task automatic t_reset();
        rst_n = 0; ctl_wr = 0; ctl_wdata = 0; xfer_err = 0;
        hst_push = 0; hst_pop = 0; hst_wdata = 0; card_ack = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(ctl_q == 32'h0, "R1 reset word", ctl_q, 0);
        check({buf_irq, dma_req, xfer_done, card_req} == 4'b0, "R1 reset outputs",
              {buf_irq, dma_req, xfer_done, card_req}, 0);
    endtask

    task automatic t_regs();
        ctl_wr = 1; ctl_wdata = 32'hFFFF_FFFF;
        @(negedge clk); ctl_wr = 0;
        check(ctl_q == 32'h5303_FFFF, "R1 field layout, R2 count too large", ctl_q, 32'h5303_FFFF);
        ctl_wr = 1; ctl_wdata = 32'h8000_0000;
        @(negedge clk); ctl_wr = 0;
        check(ctl_q == 32'h0, "R2 zero count start", ctl_q, 0);
        check(card_req == 1'b0, "R2 zero count no request", card_req, 0);
        ctl_wr = 1; ctl_wdata = 32'h8002_0000;
        @(negedge clk);
        check(ctl_q == 32'h8002_0000, "R2 max count accepted", ctl_q, 32'h8002_0000);
        ctl_wdata = 32'h0;
        @(negedge clk); ctl_wr = 0;
        check(ctl_q == 32'h0002_0000, "R10 abort keeps fields", ctl_q, 32'h0002_0000);
    endtask

    task automatic run_read(input int c, input bit w16, input bit hold, input bit dma, input bit poke);
        int left = c, k = 0, waitn = 0, evts = 0, chunk, words;
        logic [31:0] orig;
        logic [7:0]  exp;
        clr_mon();
        orig = ctlw(1, 0, dma, w16, hold, c);
        ctl_wr = 1; ctl_wdata = orig; hst_pop = 1;
        @(negedge clk); ctl_wr = 0; waitn = 1;
        while (left > 0) begin
            wait_evt(waitn);
            if (!(buf_irq || dma_req)) begin
                check(0, "R4 read pulse missing", 0, 1); left = 0; break;
            end
            chunk = (left > 512) ? 512 : left;
            if (evts == 0) begin
                words = w16 ? (chunk + 1) / 2 : chunk;
                check(waitn == words + 2, "R4 first read pulse timing", waitn, words + 2);
                if (c >= 512) check(card_req == 1'b0, "R11 card stalled on full FIFO", card_req, 0);
            end
            evts++;
            for (int i = 0; i < chunk; i++) begin
                exp = hold ? (w16 ? fpat(k % 2) : fpat(0)) : fpat(k);
                check(hst_rdata == exp, "R3 R6 read data order", hst_rdata, exp);
                if (poke && evts == 1 && i == 0) begin
                    ctl_wr = 1; ctl_wdata = ctlw(1, 1, 0, 0, 0, 3);
                end
                if (poke && evts == 1 && i == 1) begin
                    ctl_wr = 0;
                    check(ctl_q == orig, "R2 start ignored while busy", ctl_q, orig);
                end
                k++;
                if (i < chunk - 1) @(negedge clk);
            end
            left -= chunk;
            @(negedge clk);
            if (left == 0) begin
                check(xfer_done == 1'b0 && ctl_q[31], "R9 done not early", {xfer_done, ctl_q[31]}, 2'b01);
                @(negedge clk);
                check(xfer_done == 1'b1 && !ctl_q[31], "R9 done pulse and start clear",
                      {xfer_done, ctl_q[31]}, 2'b10);
            end
        end
        hst_pop = 0;
        @(negedge clk);
        check(n_done == 1, "R9 single done", n_done, 1);
        check(dma ? (n_dma == evts && n_irq == 0) : (n_irq == evts && n_dma == 0),
              "R8 pulse routing", {n_irq[15:0], n_dma[15:0]}, evts);
        check(evts == (c + 511) / 512, "R4 one pulse per chunk", evts, (c + 511) / 512);
        check(n_wide == (w16 ? c / 2 : 0) && n_narrow == (w16 ? c % 2 : c),
              "R7 word sizes", {n_wide[15:0], n_narrow[15:0]}, 0);
    endtask

    task automatic run_write(input int c, input bit w16);
        int left = c, k = 0, waitn = 0, evts = 0, chunk, w = 0;
        clr_mon();
        for (int a = 0; a < 2048; a++) cmem[a] = 8'h00;
        ctl_wr = 1; ctl_wdata = ctlw(1, 1, 0, w16, 0, c);
        hst_push = 1; hst_wdata = 8'hEE;
        @(negedge clk); ctl_wr = 0; waitn = 1;
        while (left > 0) begin
            wait_evt(waitn);
            if (!buf_irq) begin
                check(0, "R5 write pulse missing", 0, 1); left = 0; break;
            end
            if (evts == 0) check(waitn == 2, "R5 first write pulse timing", waitn, 2);
            evts++;
            chunk = (left > 512) ? 512 : left;
            for (int i = 0; i < chunk; i++) begin
                hst_wdata = gpat(k); k++;
                @(negedge clk);
            end
            hst_wdata = 8'hEE;
            left -= chunk;
        end
        while (!xfer_done && w < 4000) begin @(negedge clk); w++; end
        check(xfer_done && !ctl_q[31], "R9 write done", {xfer_done, ctl_q[31]}, 2'b10);
        hst_push = 0;
        @(negedge clk);
        check(evts == (c + 511) / 512, "R5 one pulse per chunk", evts, (c + 511) / 512);
        for (int a = 0; a < c; a++)
            check(cmem[a] == gpat(a), "R5 R6 card write data", cmem[a], gpat(a));
        check(n_wide == (w16 ? c / 2 : 0), "R7 wide words on write", n_wide, w16 ? c / 2 : 0);
    endtask

    task automatic t_abort_ctl();
        int waitn = 0;
        clr_mon();
        ctl_wr = 1; ctl_wdata = ctlw(1, 0, 0, 0, 0, 1100);
        @(negedge clk); ctl_wr = 0;
        wait_evt(waitn);
        hst_pop = 1;
        repeat (10) @(negedge clk);
        hst_pop = 0;
        ctl_wr = 1; ctl_wdata = 32'h0;
        @(negedge clk); ctl_wr = 0;
        check(ctl_q == ctlw(0, 0, 0, 0, 0, 1100), "R10 software abort", ctl_q, ctlw(0, 0, 0, 0, 0, 1100));
        check(card_req == 1'b0, "R10 card quiet after abort", card_req, 0);
        clr_mon();
        repeat (20) @(negedge clk);
        check(n_done == 0 && n_irq == 0, "R10 no done or pulse after abort", {n_done[15:0], n_irq[15:0]}, 0);
    endtask

    task automatic t_abort_err();
        int waitn = 0;
        ctl_wr = 1; ctl_wdata = ctlw(1, 1, 0, 0, 0, 100);
        @(negedge clk); ctl_wr = 0;
        wait_evt(waitn);
        hst_push = 1; hst_wdata = 8'h77;
        repeat (3) @(negedge clk);
        hst_push = 0; xfer_err = 1;
        @(negedge clk); xfer_err = 0;
        check(ctl_q[31] == 1'b0, "R10 error abort", ctl_q[31], 0);
        clr_mon();
        repeat (10) @(negedge clk);
        check(n_done == 0, "R10 no done after error", n_done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs();
        run_read(1100, 0, 0, 0, 0);
        run_read(7, 1, 1, 1, 0);
        run_read(40, 0, 0, 0, 1);
        run_write(600, 1);
        run_write(5, 0);
        t_abort_ctl();
        t_abort_err();
        run_read(4, 0, 0, 0, 0);   // R10 FIFO flushed: data and timing from empty
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule